// File: doc/BRIEF.md
# Dual-Edge Up/Down Counter with Cascade Enables

This block is a small binary counter whose value advances on both the rising and the falling edge of its clock. It is `WIDTH` bits wide (2 by default). It offers a parallel load, two independent count enables (one for counting up, one for counting down) and an asynchronous clear that overrides everything else.

Four flags come out with the count. Two terminal-count flags show whether the count sits at its top (all ones) or its bottom (all zeros). Two combinational cascade outputs pass the count enable on to the next stage at those points.

A wider counter is built by chaining identical stages. The up cascade output of one stage drives the up enable of the next, and the down cascade output drives the down enable. Clock, load and clear are shared by all stages. Because the cascade path is a single AND level per stage and every stage samples at the same edges, the chain stays in step on every edge.

Top module: `bidir_dual_edge_counter`

## Requirements
- R1: While `clear_i` is high, `count_o` is 0 immediately, without waiting for a clock edge. Clock edges, load and enables are then ignored. After release, counting starts from 0.
- R2: While `clear_i` is high, `at_top_o` is 0, `at_bottom_o` is 1, `up_carry_o` is 0 and `dn_borrow_o` is 1, whatever `dn_en_i` is.
- R3: With `load_i` high and clear low, `data_i` is copied into `count_o` on every rising and every falling clock edge, whatever the enables are.
- R4: With `up_en_i` high and load and clear low, `count_o` increases by 1 on each rising and each falling edge, wrapping from all ones to 0.
- R5: With `dn_en_i` high, `up_en_i` low and load and clear low, `count_o` decreases by 1 on each edge, wrapping from 0 to all ones.
- R6: With load and both enables low, clock edges leave `count_o` unchanged.
- R7: Outside clear, `up_carry_o` is high exactly when `up_en_i` is high and `count_o` is all ones. `dn_borrow_o` is high exactly when `dn_en_i` is high and `count_o` is 0. Both follow the enable inputs combinationally.
- R8: `at_top_o` is high exactly when `count_o` is all ones, and `at_bottom_o` exactly when it is 0, independent of the enables.
- R9: If both enables are high (a combination not supported for cascading), the counter increments.
- R10: Two stages chained up-carry to up-enable and down-borrow to down-enable, with shared clock, load and clear, count as one counter of twice the width on both edges, in both directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; both edges are active |
| clear_i | input | 1 | Asynchronous clear, active high, highest priority |
| load_i | input | 1 | Parallel load enable |
| data_i | input | WIDTH | Parallel load value |
| up_en_i | input | 1 | Count-up enable |
| dn_en_i | input | 1 | Count-down enable |
| count_o | output | WIDTH | Current count |
| at_top_o | output | 1 | Count is all ones |
| at_bottom_o | output | 1 | Count is zero |
| up_carry_o | output | 1 | Up cascade enable to the next stage |
| dn_borrow_o | output | 1 | Down cascade enable to the next stage |

## Verification
The hardest case to reach is the carry or borrow ripple between two chained stages. That ripple occurs on the falling edge as often as on the rising one, so the upper stage must step on whichever edge the lower stage wraps. The bench places a second instance behind the first and runs the pair through more than a full 4-bit cycle in each direction, comparing the joined value after every single edge.

A second hard case is the clear-state flags. In particular, the forced-high down cascade output must be checked while the down enable is held low, since otherwise the forced value cannot be told apart from the normal one.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'd0,
    OP_LOAD = 2'd1,
    OP_INC  = 2'd2,
    OP_DEC  = 2'd3
  } bdc_op_e;
endpackage

// File: rtl/bdc_next.sv
module bdc_next
  import bdc_pkg::*;
#(
  parameter int WIDTH = 2
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_en_i,
  input  logic             dn_en_i,
  output logic [WIDTH-1:0] next_o,
  output logic             en_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  bdc_op_e op;

  // load beats both enables; up beats down when both are set
  always_comb begin
    if (load_i)       op = OP_LOAD;
    else if (up_en_i) op = OP_INC;
    else if (dn_en_i) op = OP_DEC;
    else              op = OP_HOLD;
  end

  always_comb begin
    unique case (op)
      OP_LOAD: next_o = data_i;
      OP_INC:  next_o = count_i + ONE;
      OP_DEC:  next_o = count_i - ONE;
      default: next_o = count_i;
    endcase
  end

  assign en_o = (op != OP_HOLD);
endmodule

// File: rtl/bdc_edge_reg.sv
module bdc_edge_reg #(
  parameter int WIDTH   = 2,
  parameter bit FALLING = 1'b0
) (
  input  logic             clk_i,
  input  logic             clear_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] next_i,
  input  logic [WIDTH-1:0] other_i,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] state_d, state_q;

  // store next XOR partner so that state XOR partner gives the count
  always_comb begin
    state_d = state_q;
    if (en_i) state_d = next_i ^ other_i;
  end

  generate
    if (FALLING) begin : g_fall
      always_ff @(negedge clk_i or posedge clear_i) begin
        if (clear_i) state_q <= '0;
        else         state_q <= state_d;
      end
      assert_idle_keeps_R6: assert property (@(negedge clk_i) disable iff (clear_i)
        !en_i |=> $stable(state_q));
    end else begin : g_rise
      always_ff @(posedge clk_i or posedge clear_i) begin
        if (clear_i) state_q <= '0;
        else         state_q <= state_d;
      end
      assert_idle_keeps_R6: assert property (@(posedge clk_i) disable iff (clear_i)
        !en_i |=> $stable(state_q));
    end
  endgenerate

  assign state_o = state_q;
endmodule

// File: rtl/bdc_flags.sv
module bdc_flags #(
  parameter int WIDTH = 2
) (
  input  logic [WIDTH-1:0] count_i,
  input  logic             clear_i,
  input  logic             up_en_i,
  input  logic             dn_en_i,
  output logic             at_top_o,
  output logic             at_bottom_o,
  output logic             up_carry_o,
  output logic             dn_borrow_o
);
  logic full, empty;

  assign full        = &count_i;
  assign empty       = ~|count_i;
  assign at_top_o    = full;
  assign at_bottom_o = empty;
  assign up_carry_o  = up_en_i & full;
  // the down cascade reads high throughout clear
  assign dn_borrow_o = clear_i | (dn_en_i & empty);
endmodule

// File: rtl/bidir_dual_edge_counter.sv
module bidir_dual_edge_counter #(
  parameter int WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             up_en_i,
  input  logic             dn_en_i,
  output logic [WIDTH-1:0] count_o,
  output logic             at_top_o,
  output logic             at_bottom_o,
  output logic             up_carry_o,
  output logic             dn_borrow_o
);
  logic [WIDTH-1:0] rise_q, fall_q, next_val;
  logic             step_en;

  assign count_o = rise_q ^ fall_q;

  bdc_next #(.WIDTH(WIDTH)) i_next (
    .count_i (count_o),
    .load_i  (load_i),
    .data_i  (data_i),
    .up_en_i (up_en_i),
    .dn_en_i (dn_en_i),
    .next_o  (next_val),
    .en_o    (step_en)
  );

  bdc_edge_reg #(.WIDTH(WIDTH), .FALLING(1'b0)) i_rise (
    .clk_i   (clk_i),
    .clear_i (clear_i),
    .en_i    (step_en),
    .next_i  (next_val),
    .other_i (fall_q),
    .state_o (rise_q)
  );

  bdc_edge_reg #(.WIDTH(WIDTH), .FALLING(1'b1)) i_fall (
    .clk_i   (clk_i),
    .clear_i (clear_i),
    .en_i    (step_en),
    .next_i  (next_val),
    .other_i (rise_q),
    .state_o (fall_q)
  );

  bdc_flags #(.WIDTH(WIDTH)) i_flags (
    .count_i     (count_o),
    .clear_i     (clear_i),
    .up_en_i     (up_en_i),
    .dn_en_i     (dn_en_i),
    .at_top_o    (at_top_o),
    .at_bottom_o (at_bottom_o),
    .up_carry_o  (up_carry_o),
    .dn_borrow_o (dn_borrow_o)
  );

  // checker state: inputs and count seen at a rising edge, judged at the next falling edge
  logic             chk_vld_q, chk_ld_q, chk_up_q, chk_dn_q;
  logic [WIDTH-1:0] chk_cnt_q, chk_dat_q;

  always_ff @(posedge clk_i or posedge clear_i) begin
    if (clear_i) begin
      chk_vld_q <= 1'b0;
      chk_ld_q  <= 1'b0;
      chk_up_q  <= 1'b0;
      chk_dn_q  <= 1'b0;
      chk_cnt_q <= '0;
      chk_dat_q <= '0;
    end else begin
      chk_vld_q <= 1'b1;
      chk_ld_q  <= load_i;
      chk_up_q  <= up_en_i;
      chk_dn_q  <= dn_en_i;
      chk_cnt_q <= count_o;
      chk_dat_q <= data_i;
    end
  end

  assert_clear_state_R2: assert property (@(posedge clk_i)
    clear_i |-> (count_o == '0) && !at_top_o && at_bottom_o && !up_carry_o && dn_borrow_o);

  assert_load_R3: assert property (@(negedge clk_i) disable iff (clear_i)
    (chk_vld_q && chk_ld_q) |-> count_o == chk_dat_q);

  assert_inc_R4: assert property (@(negedge clk_i) disable iff (clear_i)
    (chk_vld_q && !chk_ld_q && chk_up_q) |-> count_o == WIDTH'(chk_cnt_q + WIDTH'(1)));

  assert_dec_R5: assert property (@(negedge clk_i) disable iff (clear_i)
    (chk_vld_q && !chk_ld_q && !chk_up_q && chk_dn_q) |-> count_o == WIDTH'(chk_cnt_q - WIDTH'(1)));

  assert_hold_R6: assert property (@(negedge clk_i) disable iff (clear_i)
    (chk_vld_q && !chk_ld_q && !chk_up_q && !chk_dn_q) |-> count_o == chk_cnt_q);

  assert_terminal_R8: assert property (@(posedge clk_i) disable iff (clear_i)
    !(at_top_o && at_bottom_o));
endmodule

// File: tb/test_bidir_dual_edge_counter.sv
`timescale 1ns/1ps
module test_bidir_dual_edge_counter;
  localparam int W = 2;

  logic clk = 1'b0;
  logic clear, load, up_en, dn_en;
  logic [W-1:0] data, data_hi;
  logic [W-1:0] cnt, cnt_hi;
  logic top, bot, carry, borrow;
  logic top_hi, bot_hi, carry_hi, borrow_hi;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  bidir_dual_edge_counter #(.WIDTH(W)) i_bidir_dual_edge_counter (
    .clk_i(clk), .clear_i(clear), .load_i(load), .data_i(data),
    .up_en_i(up_en), .dn_en_i(dn_en), .count_o(cnt),
    .at_top_o(top), .at_bottom_o(bot), .up_carry_o(carry), .dn_borrow_o(borrow)
  );

  bidir_dual_edge_counter #(.WIDTH(W)) i_upper_stage (
    .clk_i(clk), .clear_i(clear), .load_i(load), .data_i(data_hi),
    .up_en_i(carry), .dn_en_i(borrow), .count_o(cnt_hi),
    .at_top_o(top_hi), .at_bottom_o(bot_hi), .up_carry_o(carry_hi), .dn_borrow_o(borrow_hi)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // wait for the next clock edge of either polarity, then settle
  task automatic next_edge();
    @(posedge clk or negedge clk);
    #2;
  endtask

  task automatic do_load(input int v);
    load = 1'b1; data = W'(v);
    next_edge();
    load = 1'b0;
  endtask

  task automatic test_reset();
    clear = 1'b1; load = 1'b1; data = '1; up_en = 1'b1; dn_en = 1'b0;
    data_hi = '1;
    next_edge(); next_edge(); next_edge();
    check("R1 count during clear", cnt, 0);
    up_en = 1'b0;
    #1;
    check("R2 at_top in clear", top, 0);
    check("R2 at_bottom in clear", bot, 1);
    check("R2 up_carry in clear", carry, 0);
    check("R2 dn_borrow in clear with dn_en low", borrow, 1);
    load = 1'b0;
    next_edge();
    clear = 1'b0;
    next_edge();
    check("R1 count after release", cnt, 0);
  endtask

  task automatic test_async_clear();
    do_load(2);
    check("R3 load before clear", cnt, 2);
    #3;
    clear = 1'b1;
    #1;
    check("R1 clear between edges", cnt, 0);
    next_edge();
    clear = 1'b0;
  endtask

  task automatic test_load();
    load = 1'b1; up_en = 1'b1; data = 2'd3;
    next_edge();
    check("R3 load edge a", cnt, 3);
    data = 2'd1;
    next_edge();
    check("R3 load edge b", cnt, 1);
    load = 1'b0; up_en = 1'b0;
  endtask

  task automatic test_inc();
    do_load(0);
    up_en = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      next_edge();
      check("R4 increment", cnt, k % 4);
    end
    up_en = 1'b0;
  endtask

  task automatic test_dec();
    do_load(1);
    dn_en = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      next_edge();
      check("R5 decrement", cnt, ((1 - k) % 4 + 4) % 4);
    end
    dn_en = 1'b0;
  endtask

  task automatic test_hold();
    do_load(2);
    for (int k = 0; k < 4; k++) next_edge();
    check("R6 hold", cnt, 2);
  endtask

  task automatic test_flags();
    do_load(3);
    check("R8 at_top at max", top, 1);
    check("R8 at_bottom at max", bot, 0);
    check("R7 up_carry with up_en low", carry, 0);
    up_en = 1'b1; #1;
    check("R7 up_carry with up_en high", carry, 1);
    up_en = 1'b0;
    do_load(0);
    check("R8 at_bottom at zero", bot, 1);
    check("R7 dn_borrow with dn_en low", borrow, 0);
    dn_en = 1'b1; #1;
    check("R7 dn_borrow with dn_en high", borrow, 1);
    dn_en = 1'b0;
    do_load(1); dn_en = 1'b1; #1;
    check("R7 dn_borrow off at nonzero", borrow, 0);
    dn_en = 1'b0;
  endtask

  task automatic test_both();
    do_load(1);
    up_en = 1'b1; dn_en = 1'b1;
    next_edge();
    check("R9 both enables edge a", cnt, 2);
    next_edge();
    check("R9 both enables edge b", cnt, 3);
    up_en = 1'b0; dn_en = 1'b0;
  endtask

  task automatic test_cascade();
    load = 1'b1; data = '0; data_hi = '0;
    next_edge();
    load = 1'b0;
    check("R10 chain loaded", {cnt_hi, cnt}, 0);
    up_en = 1'b1;
    for (int k = 1; k <= 18; k++) begin
      next_edge();
      check("R10 chain up", {cnt_hi, cnt}, k % 16);
    end
    up_en = 1'b0;
    dn_en = 1'b1;
    for (int k = 1; k <= 18; k++) begin
      next_edge();
      check("R10 chain down", {cnt_hi, cnt}, ((2 - k) % 16 + 16) % 16);
    end
    dn_en = 1'b0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    clear = 1'b1; load = 1'b0; up_en = 1'b0; dn_en = 1'b0;
    data = '0; data_hi = '0;
    #5;
    test_reset();
    test_async_clear();
    test_load();
    test_inc();
    test_dec();
    test_hold();
    test_flags();
    test_both();
    test_cascade();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule